// File: doc/BRIEF.md
# Interval Timer, Stopwatch and Interrupt Level Controller

This peripheral combines three small functions that share one byte-wide register port. A reloadable 8-bit interval timer counts down on a prescaled tick input and raises a level-3 request each time it expires, provided that level is enabled. A 12-bit stopwatch counts the same ticks and wraps. A pending/enable unit for six interrupt levels collects event inputs and the timer request. It produces the CPU priority level, which is the highest level that is both pending and enabled.

Software programs the period, the enable mask and the stopwatch through write strobes with a 3-bit register select. It can read the period, the mask, a status byte, both stopwatch bytes and the pending set back through a combinational read port. The CPU returns an acknowledge with a level, and this retires that level's pending bit. The prescaler and the circuits that produce the events sit outside the block.

Top module: `tic_ctrl`

## Requirements
- R1: Writing a nonzero value N to the period register (select 0) loads the countdown with N. After N ticks the timer expires, reloads from the period register and keeps repeating every N ticks. The pending byte (select 5) shows level L in bit L.
- R2: Writing zero to the period register stops the timer, and no further expiry occurs however many ticks arrive.
- R3: An expiry sets pending level 3 only if mask bit 3 is set when it happens. Event input level 3 is ignored because the timer owns that level.
- R4: The stopwatch increments on every tick and wraps from 0xFFF to 0. Select 3 reads its low byte and select 4 reads its upper nibble in bits 3:0.
- R5: A write of any data to select 3 or select 4 clears the stopwatch to zero, even if a tick arrives in the same cycle.
- R6: A mask write (select 1) with data bit 1 set clears pending level 1. A mask write with bit 1 clear leaves pending level 1 unchanged.
- R7: Status (select 2) bit 7 mirrors mask bit 2. Status bit 0 is set by an event on level 2. All other status bits read 0.
- R8: The drive-status event (event input level 4) sets pending level 4. That level reaches the output only while mask bit 4 is set.
- R9: An acknowledge at level L (1 to 6) clears pending bit L. An acknowledge at level 2 also clears status bit 0. An event arriving in the same cycle wins over the clear, and acknowledge levels 0 and 7 have no effect.
- R10: The output level is the highest level L in 1 to 6 whose pending bit and mask bit are both set, or 0 when there is none. It is registered, so it follows the pending and mask state one cycle later.
- R11: Reset clears the period, countdown, stopwatch, mask, pending bits, status flag and output level.
- R12: Writes to selects 2, 5, 6 and 7 change nothing, and reads of selects 6 and 7 return 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tick | input | 1 | Prescaled time-base strobe |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 3 | Register select for the write |
| wr_data | input | 8 | Write data |
| rd_addr | input | 3 | Register select for the read |
| rd_data | output | 8 | Combinational read data |
| ext_evt | input | 6 | Event pulses, bit L for level L (bit 4 is the drive-status event) |
| ack_valid | input | 1 | Interrupt acknowledge strobe |
| ack_level | input | 3 | Level being acknowledged |
| irq_level | output | 3 | Highest enabled pending level, 0 when none |

## Verification
On every cycle the assertions check several rules. The output level stays in range, is zero when no request was active, and names an active request with nothing active above it. Level 3 never becomes pending while its mask bit is clear or while the timer is stopped. The stopwatch steps by exactly one per tick and reads zero after a clearing write. An acknowledge or a dropping mask write leaves the retired bit clear. Other behaviours are shown only by the bench's scenarios: the exact N-tick expiry period and its reload, the wrap at 4096 ticks, the status mirror, the same-cycle precedence of events over clears, and the full register readback compared against an independent cycle model under random traffic.

// File: rtl/tic_pkg.sv
package tic_pkg;

    localparam int LVL_N    = 6;
    localparam int LVL_W    = 3;
    localparam int DATA_W   = 8;
    localparam int ADDR_W   = 3;

    // Levels with fixed roles
    localparam int LVL_DROP = 1;   // cleared by a mask write with this bit set
    localparam int LVL_HOST = 2;   // also drives the status flag
    localparam int LVL_TMR  = 3;   // owned by the interval timer
    localparam int LVL_DRV  = 4;   // drive-status event

    localparam int ST_FLAG_BIT   = 0;
    localparam int ST_MIRROR_BIT = 7;

    typedef enum logic [ADDR_W-1:0] {
        RA_PERIOD = 3'd0,
        RA_MASK   = 3'd1,
        RA_STATUS = 3'd2,
        RA_SW_LO  = 3'd3,
        RA_SW_HI  = 3'd4,
        RA_PEND   = 3'd5
    } reg_addr_e;

    typedef struct packed {
        logic              en;
        reg_addr_e         addr;
        logic [DATA_W-1:0] data;
    } wr_req_t;

    typedef logic [LVL_N:1] lvl_vec_t;

    // Highest set level, 0 when the vector is empty
    function automatic logic [LVL_W-1:0] top_level(input lvl_vec_t act);
        logic [LVL_W-1:0] r;
        r = '0;
        for (int i = 1; i <= LVL_N; i++) begin
            if (act[i]) r = LVL_W'(i);
        end
        return r;
    endfunction

endpackage

// File: rtl/tic_timer.sv
module tic_timer
    import tic_pkg::*;
#(
    parameter int TMR_W = 8,
    parameter int SW_W  = 12
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             tick,
    input  logic             per_we,
    input  logic [TMR_W-1:0] per_data,
    input  logic             sw_clr,
    output logic [TMR_W-1:0] per_q,
    output logic [SW_W-1:0]  sw_q,
    output logic             expire,
    output logic             live
);

    logic [TMR_W-1:0] cnt_q;

    assign live   = (cnt_q != '0);
    assign expire = !per_we && tick && (cnt_q == TMR_W'(1));

    // Countdown with reload; a write always takes precedence
    always_ff @(posedge clk) begin
        if (rst) begin
            per_q <= '0;
            cnt_q <= '0;
        end else if (per_we) begin
            per_q <= per_data;
            cnt_q <= per_data;
        end else if (tick && live) begin
            if (cnt_q == TMR_W'(1)) cnt_q <= per_q;
            else                    cnt_q <= cnt_q - TMR_W'(1);
        end
    end

    // Free-running stopwatch
    always_ff @(posedge clk) begin
        if (rst || sw_clr) sw_q <= '0;
        else if (tick)     sw_q <= sw_q + SW_W'(1);
    end

endmodule

// File: rtl/tic_pend.sv
module tic_pend
    import tic_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              mask_we,
    input  logic [DATA_W-1:0] mask_data,
    input  lvl_vec_t          ev,
    input  logic              tmr_expire,
    input  logic              ack_valid,
    input  logic [LVL_W-1:0]  ack_level,
    output logic [DATA_W-1:0] mask_q,
    output lvl_vec_t          pend_q,
    output logic              flag_q
);

    lvl_vec_t set_v;
    lvl_vec_t clr_v;

    generate
        for (genvar l = 1; l <= LVL_N; l++) begin : g_lvl
            logic ack_hit;
            assign ack_hit = ack_valid && (ack_level == LVL_W'(l));

            if (l == LVL_TMR) begin : g_tmr
                assign set_v[l] = tmr_expire && mask_q[l];
            end else begin : g_evt
                assign set_v[l] = ev[l];
            end

            if (l == LVL_DROP) begin : g_drop
                assign clr_v[l] = ack_hit || (mask_we && mask_data[l]);
            end else begin : g_plain
                assign clr_v[l] = ack_hit;
            end

            // A new request outranks a same-cycle clear
            always_ff @(posedge clk) begin
                if (rst)           pend_q[l] <= 1'b0;
                else if (set_v[l]) pend_q[l] <= 1'b1;
                else if (clr_v[l]) pend_q[l] <= 1'b0;
            end
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (rst)          mask_q <= '0;
        else if (mask_we) mask_q <= mask_data;
    end

    always_ff @(posedge clk) begin
        if (rst)                                          flag_q <= 1'b0;
        else if (ev[LVL_HOST])                            flag_q <= 1'b1;
        else if (ack_valid && ack_level == LVL_W'(LVL_HOST)) flag_q <= 1'b0;
    end

endmodule

// File: rtl/tic_ctrl.sv
module tic_ctrl
    import tic_pkg::*;
#(
    parameter int SW_W = 12
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              tick,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [DATA_W-1:0] rd_data,
    input  logic [LVL_N:1]    ext_evt,
    input  logic              ack_valid,
    input  logic [LVL_W-1:0]  ack_level,
    output logic [LVL_W-1:0]  irq_level
);

    localparam int SW_HI_W = SW_W - DATA_W;

    wr_req_t           wreq;
    logic              per_we;
    logic              mask_we;
    logic              sw_clr;
    logic [DATA_W-1:0] per_q;
    logic [SW_W-1:0]   sw_q;
    logic              tmr_expire;
    logic              tmr_live;
    logic [DATA_W-1:0] mask_q;
    lvl_vec_t          pend_q;
    logic              flag_q;
    lvl_vec_t          active;
    logic [DATA_W-1:0] status;

    assign wreq.en   = wr_en;
    assign wreq.addr = reg_addr_e'(wr_addr);
    assign wreq.data = wr_data;

    assign per_we  = wreq.en && (wreq.addr == RA_PERIOD);
    assign mask_we = wreq.en && (wreq.addr == RA_MASK);
    assign sw_clr  = wreq.en && (wreq.addr == RA_SW_LO || wreq.addr == RA_SW_HI);

    tic_timer #(
        .TMR_W (DATA_W),
        .SW_W  (SW_W)
    ) u_tmr (
        .clk      (clk),
        .rst      (rst),
        .tick     (tick),
        .per_we   (per_we),
        .per_data (wreq.data),
        .sw_clr   (sw_clr),
        .per_q    (per_q),
        .sw_q     (sw_q),
        .expire   (tmr_expire),
        .live     (tmr_live)
    );

    tic_pend u_pend (
        .clk        (clk),
        .rst        (rst),
        .mask_we    (mask_we),
        .mask_data  (wreq.data),
        .ev         (ext_evt),
        .tmr_expire (tmr_expire),
        .ack_valid  (ack_valid),
        .ack_level  (ack_level),
        .mask_q     (mask_q),
        .pend_q     (pend_q),
        .flag_q     (flag_q)
    );

    assign active = pend_q & mask_q[LVL_N:1];

    always_ff @(posedge clk) begin
        if (rst) irq_level <= '0;
        else     irq_level <= top_level(active);
    end

    always_comb begin
        status                = '0;
        status[ST_MIRROR_BIT] = mask_q[LVL_HOST];
        status[ST_FLAG_BIT]   = flag_q;
    end

    always_comb begin
        case (rd_addr)
            RA_PERIOD: rd_data = per_q;
            RA_MASK:   rd_data = mask_q;
            RA_STATUS: rd_data = status;
            RA_SW_LO:  rd_data = sw_q[DATA_W-1:0];
            RA_SW_HI:  rd_data = DATA_W'({sw_q[SW_W-1 -: SW_HI_W]});
            RA_PEND:   rd_data = {1'b0, pend_q, 1'b0};
            default:   rd_data = '0;
        endcase
    end

endmodule

// File: rtl/tic_ctrl_chk.sv
module tic_ctrl_chk
    import tic_pkg::*;
#(
    parameter int SW_W = 12
) (
    input logic              clk,
    input logic              rst,
    input logic              tick,
    input logic              wr_en,
    input logic [ADDR_W-1:0] wr_addr,
    input logic [DATA_W-1:0] wr_data,
    input logic [LVL_N:1]    ext_evt,
    input logic              ack_valid,
    input logic [LVL_W-1:0]  ack_level,
    input logic [LVL_W-1:0]  irq_level,
    input logic [LVL_N:1]    pend_q,
    input logic [DATA_W-1:0] mask_q,
    input logic              flag_q,
    input logic [SW_W-1:0]   sw_q,
    input logic              tmr_live
);

    logic [LVL_N:0] act_prev;
    logic           swclr;

    assign swclr = wr_en && (wr_addr == 3'd3 || wr_addr == 3'd4);

    always_ff @(posedge clk) begin
        if (rst) act_prev <= '0;
        else     act_prev <= {pend_q & mask_q[LVL_N:1], 1'b0};
    end

    AST_LEVEL_RANGE: assert property (@(posedge clk) disable iff (rst)
        irq_level <= LVL_W'(LVL_N)); // R10

    AST_IDLE_NO_REQ: assert property (@(posedge clk) disable iff (rst)
        (act_prev == '0) |-> (irq_level == '0)); // R10

    AST_LEVEL_IS_TOP: assert property (@(posedge clk) disable iff (rst)
        (irq_level != '0) |-> (act_prev[irq_level] && ((act_prev >> irq_level) == 1))); // R10

    AST_TMR_GATED: assert property (@(posedge clk) disable iff (rst)
        $rose(pend_q[LVL_TMR]) |-> $past(mask_q[LVL_TMR])); // R3

    AST_TMR_STOPPED: assert property (@(posedge clk) disable iff (rst)
        $past(!tmr_live && !(wr_en && wr_addr == 3'd0)) |-> !$rose(pend_q[LVL_TMR])); // R2

    AST_SW_CLEAR: assert property (@(posedge clk) disable iff (rst)
        $past(swclr) |-> (sw_q == '0)); // R5

    AST_SW_STEP: assert property (@(posedge clk) disable iff (rst)
        $past(tick && !swclr) |-> (sw_q == SW_W'($past(sw_q) + SW_W'(1)))); // R4

    AST_HOST_ACK: assert property (@(posedge clk) disable iff (rst)
        $past(ack_valid && ack_level == 3'd2 && !ext_evt[LVL_HOST]) |-> !flag_q); // R9

    AST_DROP_LVL1: assert property (@(posedge clk) disable iff (rst)
        $past(wr_en && wr_addr == 3'd1 && wr_data[LVL_DROP] && !ext_evt[LVL_DROP])
        |-> !pend_q[LVL_DROP]); // R6

endmodule

bind tic_ctrl tic_ctrl_chk #(.SW_W(SW_W)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .tick      (tick),
    .wr_en     (wr_en),
    .wr_addr   (wr_addr),
    .wr_data   (wr_data),
    .ext_evt   (ext_evt),
    .ack_valid (ack_valid),
    .ack_level (ack_level),
    .irq_level (irq_level),
    .pend_q    (pend_q),
    .mask_q    (mask_q),
    .flag_q    (flag_q),
    .sw_q      (sw_q),
    .tmr_live  (tmr_live)
);

// File: tb/tic_ctrl_test.sv
module tic_ctrl_test;

    localparam int CLK_PERIOD = 20;
    localparam int WATCHDOG   = 200000;

    logic       clk = 1'b0;
    logic       rst;
    logic       tick;
    logic       wr_en;
    logic [2:0] wr_addr;
    logic [7:0] wr_data;
    logic [2:0] rd_addr;
    logic [7:0] rd_data;
    logic [6:1] ext_evt;
    logic       ack_valid;
    logic [2:0] ack_level;
    logic [2:0] irq_level;

    int n_chk  = 0;
    int n_fail = 0;
    bit done   = 0;

    // Reference state
    logic [7:0]  m_per, m_cnt, m_mask;
    logic [11:0] m_sw;
    logic [6:1]  m_pend;
    logic        m_flag;
    logic [2:0]  m_lvl;

    tic_ctrl uut (
        .clk       (clk),
        .rst       (rst),
        .tick      (tick),
        .wr_en     (wr_en),
        .wr_addr   (wr_addr),
        .wr_data   (wr_data),
        .rd_addr   (rd_addr),
        .rd_data   (rd_data),
        .ext_evt   (ext_evt),
        .ack_valid (ack_valid),
        .ack_level (ack_level),
        .irq_level (irq_level)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    function automatic logic [2:0] highest(input logic [6:1] v);
        for (int i = 6; i >= 1; i--) if (v[i]) return 3'(i);
        return 3'd0;
    endfunction

    function automatic logic [7:0] exp_rd(input logic [2:0] a);
        case (a)
            3'd0: return m_per;
            3'd1: return m_mask;
            3'd2: return {m_mask[2], 6'd0, m_flag};
            3'd3: return m_sw[7:0];
            3'd4: return {4'd0, m_sw[11:8]};
            3'd5: return {1'b0, m_pend, 1'b0};
            default: return 8'd0;
        endcase
    endfunction

    function automatic string tag_of(input logic [2:0] a);
        case (a)
            3'd0: return "R1";
            3'd1: return "R6";
            3'd2: return "R7";
            3'd3: return "R4";
            3'd4: return "R4";
            3'd5: return "R9";
            default: return "R12";
        endcase
    endfunction

    task automatic chk(input string tag, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h at %0t", tag, act, exp, $time);
        end
    endtask

    task automatic peek(input logic [2:0] a, input logic [7:0] exp, input string tag);
        rd_addr = a;
        #1;
        chk(tag, rd_data, exp);
    endtask

    task automatic compare_all();
        chk("R10", irq_level, m_lvl);
        for (int a = 0; a < 7; a++) begin
            rd_addr = 3'(a);
            #1;
            chk(tag_of(3'(a)), rd_data, exp_rd(3'(a)));
        end
    endtask

    task automatic model_step(input logic we, input logic [2:0] wa, input logic [7:0] wd,
                              input logic tk, input logic [6:1] ev,
                              input logic av, input logic [2:0] al);
        logic [7:0]  n_per, n_cnt, n_mask;
        logic [11:0] n_sw;
        logic [6:1]  n_pend;
        logic        n_flag, ex;
        n_per = m_per; n_cnt = m_cnt; n_mask = m_mask; n_sw = m_sw;
        n_pend = m_pend; n_flag = m_flag; ex = 1'b0;
        if (we && wa == 3'd0) begin
            n_per = wd; n_cnt = wd;
        end else if (tk && m_cnt != 0) begin
            if (m_cnt == 1) begin n_cnt = m_per; ex = 1'b1; end
            else n_cnt = m_cnt - 1;
        end
        if (we && (wa == 3'd3 || wa == 3'd4)) n_sw = 12'd0;
        else if (tk) n_sw = m_sw + 12'd1;
        if (av && al >= 1 && al <= 6) n_pend[al] = 1'b0;
        if (we && wa == 3'd1 && wd[1]) n_pend[1] = 1'b0;
        for (int l = 1; l <= 6; l++) if (l != 3 && ev[l]) n_pend[l] = 1'b1;
        if (ex && m_mask[3]) n_pend[3] = 1'b1;
        if (av && al == 3'd2) n_flag = 1'b0;
        if (ev[2]) n_flag = 1'b1;
        if (we && wa == 3'd1) n_mask = wd;
        m_lvl  = highest(m_pend & m_mask[6:1]);
        m_per = n_per; m_cnt = n_cnt; m_mask = n_mask; m_sw = n_sw;
        m_pend = n_pend; m_flag = n_flag;
    endtask

    task automatic cyc(input logic we, input logic [2:0] wa, input logic [7:0] wd,
                       input logic tk, input logic [6:1] ev,
                       input logic av, input logic [2:0] al);
        wr_en = we; wr_addr = wa; wr_data = wd; tick = tk;
        ext_evt = ev; ack_valid = av; ack_level = al;
        model_step(we, wa, wd, tk, ev, av, al);
        @(posedge clk);
        @(negedge clk);
        wr_en = 0; tick = 0; ext_evt = '0; ack_valid = 0;
        compare_all();
    endtask

    task automatic wr(input logic [2:0] a, input logic [7:0] d);
        cyc(1'b1, a, d, 1'b0, 6'd0, 1'b0, 3'd0);
    endtask

    task automatic ticks(input int n);
        for (int i = 0; i < n; i++) cyc(1'b0, 3'd0, 8'd0, 1'b1, 6'd0, 1'b0, 3'd0);
    endtask

    task automatic evt(input logic [6:1] e);
        cyc(1'b0, 3'd0, 8'd0, 1'b0, e, 1'b0, 3'd0);
    endtask

    task automatic ack(input logic [2:0] l);
        cyc(1'b0, 3'd0, 8'd0, 1'b0, 6'd0, 1'b1, l);
    endtask

    task automatic idle();
        cyc(1'b0, 3'd0, 8'd0, 1'b0, 6'd0, 1'b0, 3'd0);
    endtask

    initial begin
        #(CLK_PERIOD * WATCHDOG);
        if (!done) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd2024));
        rst = 1; tick = 0; wr_en = 0; wr_addr = 0; wr_data = 0; rd_addr = 0;
        ext_evt = '0; ack_valid = 0; ack_level = 0;
        m_per = 0; m_cnt = 0; m_mask = 0; m_sw = 0; m_pend = '0; m_flag = 0; m_lvl = 0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 0;

        // R11 reset state
        chk("R11", irq_level, 0);
        for (int a = 0; a < 8; a++) peek(3'(a), 8'd0, "R11");

        // R1 / R3: period 3 with level 3 enabled
        wr(3'd1, 8'h08);
        wr(3'd0, 8'd3);
        ticks(2);
        peek(3'd5, 8'h00, "R1");
        ticks(1);
        peek(3'd5, 8'h08, "R1");
        idle();
        chk("R10", irq_level, 3);
        ack(3'd3);
        peek(3'd5, 8'h00, "R9");
        ticks(3);
        peek(3'd5, 8'h08, "R1");
        ack(3'd3);

        // R3: expiry with mask clear posts nothing
        wr(3'd1, 8'h00);
        ticks(3);
        peek(3'd5, 8'h00, "R3");
        evt(6'b000100);
        peek(3'd5, 8'h00, "R3");

        // R2: zero period stops the timer
        wr(3'd1, 8'h08);
        wr(3'd0, 8'd0);
        ticks(10);
        peek(3'd5, 8'h00, "R2");

        // R5 then R4 wrap
        wr(3'd3, 8'h5A);
        peek(3'd3, 8'h00, "R5");
        ticks(4095);
        peek(3'd3, 8'hFF, "R4");
        peek(3'd4, 8'h0F, "R4");
        ticks(1);
        peek(3'd3, 8'h00, "R4");
        peek(3'd4, 8'h00, "R4");
        ticks(5);
        cyc(1'b1, 3'd4, 8'h00, 1'b1, 6'd0, 1'b0, 3'd0);
        peek(3'd3, 8'h00, "R5");

        // R6 / R7: drop of level 1 and mirror of mask bit 2
        evt(6'b000001);
        peek(3'd5, 8'h02, "R6");
        wr(3'd1, 8'h04);
        peek(3'd5, 8'h02, "R6");
        peek(3'd2, 8'h80, "R7");
        wr(3'd1, 8'h02);
        peek(3'd5, 8'h00, "R6");
        peek(3'd2, 8'h00, "R7");

        // R7 / R9: host event flag and its acknowledge
        evt(6'b000010);
        peek(3'd2, 8'h01, "R7");
        ack(3'd2);
        peek(3'd2, 8'h00, "R9");
        peek(3'd5, 8'h00, "R9");
        cyc(1'b0, 3'd0, 8'd0, 1'b0, 6'b000010, 1'b1, 3'd2);
        peek(3'd5, 8'h04, "R9");
        ack(3'd7);
        peek(3'd5, 8'h04, "R9");
        ack(3'd2);

        // R8: drive event gated by mask bit 4
        wr(3'd1, 8'h00);
        evt(6'b001000);
        idle();
        peek(3'd5, 8'h10, "R8");
        chk("R8", irq_level, 0);
        wr(3'd1, 8'h10);
        idle();
        chk("R8", irq_level, 4);

        // R10: priority among several
        evt(6'b100001);
        wr(3'd1, 8'h7E);
        idle();
        chk("R10", irq_level, 6);
        ack(3'd6);
        idle();
        chk("R10", irq_level, 4);

        // R12: ignored writes
        wr(3'd2, 8'hFF);
        wr(3'd5, 8'hFF);
        wr(3'd6, 8'hFF);
        wr(3'd7, 8'hFF);
        peek(3'd6, 8'h00, "R12");
        peek(3'd7, 8'h00, "R12");
        peek(3'd2, 8'h80, "R12");

        // Constrained random traffic against the model
        for (int i = 0; i < 4000; i++) begin
            logic       we, tk, av;
            logic [2:0] wa, al;
            logic [7:0] wd;
            logic [6:1] ev;
            we = ($urandom_range(0, 9) == 0);
            wa = 3'($urandom_range(0, 7));
            wd = 8'($urandom);
            if (wa == 3'd0) wd = 8'($urandom_range(0, 5));
            tk = ($urandom_range(0, 1) == 1);
            ev = '0;
            for (int l = 1; l <= 6; l++) ev[l] = ($urandom_range(0, 11) == 0);
            av = ($urandom_range(0, 5) == 0);
            al = 3'($urandom_range(0, 7));
            cyc(we, wa, wd, tk, ev, av, al);
        end

        done = 1;
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
        $finish;
    end

endmodule